// File: doc/BRIEF.md
# Space-Vector PWM Reference Generator

This block turns a stationary-frame voltage command (alpha, beta) into three phase modulation references for a two-level three-phase inverter. When these references drive an ordinary triangle-carrier comparator, the result is space-vector switching. In each carrier period the two active vectors next to the command's sector are applied, and the zero-vector time is split evenly between the all-low and all-high leg states. The values are Q1.15 two's complement, where -32768 means -1.0 and 32767 means just under +1.0. Exactly one command set is expected per PWM period.

The datapath has four register stages:
1. An inverse Clarke transform.
2. Extraction of the largest and smallest phase voltage.
3. Common-mode injection of minus half their sum.
4. A gain of 2/sqrt(3) followed by clamping.

Inputs and outputs use valid/ready handshakes:
- An input set is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A result is delivered on an edge where `out_valid` and `out_ready` are both high.
- While a result waits unaccepted, the whole pipeline stalls. In that state `in_ready` is low and the outputs do not move.
- Between results the output values stay where they were.

Top module: `svpwm_refgen`

## Requirements
- R1: Phase voltages use K = 28378 and kb = floor((K*beta + 16384) / 32768). They are va = alpha, vb = kb - floor(alpha/2) and vc = -kb - floor(alpha/2), all carried with two guard bits (18-bit signed).
- R2: The common-mode offset is off = -floor((max(va,vb,vc) + min(va,vb,vc)) / 2). It is added to all three phase voltages, so the largest and smallest shifted voltages sum to 0 or 1. A zero command gives three zero outputs.
- R3: Each shifted voltage x is scaled to floor((x*18919 + 8192) / 16384), which is a gain of 2/sqrt(3) with the constant in Q2.14. The outputs are refA, refB and refC for phases a, b and c respectively.
- R4: A scaled value above 32767 is output as 32767, and one below -32768 as -32768. No value wraps, and each output keeps the sign of its shifted voltage. For example, alpha = beta = 32767 gives refA = 32767 and refC = -32768.
- R5: With `out_ready` held high, a set accepted on rising edge n appears with `out_valid` high after rising edge n+3, that is four register stages. `out_valid` pulses for exactly one cycle per accepted set, and back-to-back sets stream at one per cycle.
- R6: While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` hold, `in_ready` is low, and no set is lost or duplicated.
- R7: When no new result arrives, refA, refB and refC keep their last values.
- R8: A synchronous active-high reset clears all three outputs to 0 (50% duty on every leg) and `out_valid` to 0, and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command set present on alpha/beta |
| in_ready | output | 1 | Block can take a command set this cycle |
| alpha | input | 16 | Alpha command, Q1.15 signed |
| beta | input | 16 | Beta command, Q1.15 signed |
| out_valid | output | 1 | References hold a new result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| ref_a | output | 16 | Phase a reference, Q1.15 signed |
| ref_b | output | 16 | Phase b reference, Q1.15 signed |
| ref_c | output | 16 | Phase c reference, Q1.15 signed |

## Verification
The bench sweeps a 17 by 17 grid of alpha and beta that includes both full-scale extremes. It compares every result with integer arithmetic worked out from the formulas above. A wrong rounding constant or a truncating shift would be off by one count on many grid points. A dropped common-mode offset would give plain sinusoidal values. Corners whose scaled value exceeds full scale catch a saturation that wraps to the opposite sign. The same sweep is also run under an irregular `out_ready` pattern. That pattern exposes a pipeline that loses, repeats or changes a result while it waits. A single-command test checks the four-stage latency and that the outputs hold afterwards, which catches an off-by-one valid pipe or outputs that reload from stale stages.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  localparam int NPH = 3;
  localparam int PH_A = 0;
  localparam int PH_B = 1;
  localparam int PH_C = 2;
endpackage

// File: rtl/svpwm_clarke.sv
module svpwm_clarke
  import svpwm_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 28378
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] alpha,
  input  logic signed [W-1:0] beta,
  output logic signed [W+1:0] v [NPH]
);
  localparam int GW = W + 2;
  localparam logic signed [W:0]   KS  = (W+1)'(K);
  localparam logic signed [2*W:0] RND = (2*W+1)'(1) <<< (W-2);

  logic signed [2*W:0]  prod;
  logic signed [2*W:0]  prod_r;
  logic signed [GW-1:0] kb;
  logic signed [GW-1:0] a_ext;
  logic signed [GW-1:0] half;

  // sqrt(3)/2 * beta, rounded to nearest (ties up)
  assign prod   = beta * KS;
  assign prod_r = prod + RND;
  assign kb     = prod_r[2*W:W-1];
  assign a_ext  = {{2{alpha[W-1]}}, alpha};
  assign half   = a_ext >>> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPH; i++) v[i] <= '0;
    end else if (en) begin
      v[PH_A] <= a_ext;
      v[PH_B] <= kb - half;
      v[PH_C] <= -kb - half;
    end
  end

  AST_VA_PASS: assert property (@(posedge clk) disable iff (rst)
    en |=> v[PH_A] == {{2{$past(alpha[W-1])}}, $past(alpha)}); // R1
endmodule

// File: rtl/svpwm_minmax.sv
module svpwm_minmax
  import svpwm_pkg::*;
#(
  parameter int GW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [GW-1:0] v  [NPH],
  output logic signed [GW-1:0] p  [NPH],
  output logic signed [GW-1:0] mx,
  output logic signed [GW-1:0] mn
);
  logic signed [GW-1:0] mx_c;
  logic signed [GW-1:0] mn_c;

  always_comb begin
    mx_c = v[0];
    mn_c = v[0];
    for (int i = 1; i < NPH; i++) begin
      if (v[i] > mx_c) mx_c = v[i];
      if (v[i] < mn_c) mn_c = v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPH; i++) p[i] <= '0;
      mx <= '0;
      mn <= '0;
    end else if (en) begin
      for (int i = 0; i < NPH; i++) p[i] <= v[i];
      mx <= mx_c;
      mn <= mn_c;
    end
  end

  AST_EXTREMES_BOUND: assert property (@(posedge clk) disable iff (rst)
    en |=> (mn <= p[PH_A]) && (p[PH_A] <= mx) && (mn <= p[PH_B]) && (p[PH_B] <= mx)
        && (mn <= p[PH_C]) && (p[PH_C] <= mx)); // R2
endmodule

// File: rtl/svpwm_inject.sv
module svpwm_inject
  import svpwm_pkg::*;
#(
  parameter int GW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [GW-1:0] p  [NPH],
  input  logic signed [GW-1:0] mx,
  input  logic signed [GW-1:0] mn,
  output logic signed [GW-1:0] r  [NPH]
);
  logic signed [GW:0] sum;
  logic signed [GW:0] off;
  logic signed [GW:0] t [NPH];

  assign sum = mx + mn;
  assign off = -(sum >>> 1);

  for (genvar i = 0; i < NPH; i++) begin : g_shift
    assign t[i] = p[i] + off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPH; i++) r[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < NPH; i++) r[i] <= t[i][GW-1:0];
    end
  end

  // extremes of the shifted set, for the balance check
  logic signed [GW-1:0] rmx;
  logic signed [GW-1:0] rmn;
  logic signed [GW:0]   bal;
  always_comb begin
    rmx = r[0];
    rmn = r[0];
    for (int i = 1; i < NPH; i++) begin
      if (r[i] > rmx) rmx = r[i];
      if (r[i] < rmn) rmn = r[i];
    end
  end
  assign bal = rmx + rmn;

  AST_CM_BALANCED: assert property (@(posedge clk) disable iff (rst)
    en |=> (bal == 0) || (bal == 1)); // R2
endmodule

// File: rtl/svpwm_scale.sv
module svpwm_scale
  import svpwm_pkg::*;
#(
  parameter int W  = 16,
  parameter int GW = 18,
  parameter int G  = 18919
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [GW-1:0] r [NPH],
  output logic signed [W-1:0]  o [NPH]
);
  localparam int PW = GW + W + 1;
  localparam logic signed [W:0]    GS   = (W+1)'(G);
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (W-3);
  localparam logic signed [PW-1:0] MAXV = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] q;
    logic signed [W-1:0]  sat;

    assign prod = r[i] * GS;
    assign q    = (prod + RND) >>> (W-2);

    always_comb begin
      if (q > MAXV)      sat = MAXV[W-1:0];
      else if (q < MINV) sat = MINV[W-1:0];
      else               sat = q[W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)     o[i] <= '0;
      else if (en) o[i] <= sat;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      en |=> (($past(r[i]) < 0) == (o[i] < 0))); // R4
  end
endmodule

// File: rtl/svpwm_refgen.sv
module svpwm_refgen
  import svpwm_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 28378,
  parameter int G = 18919
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] alpha,
  input  logic signed [W-1:0] beta,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] ref_a,
  output logic signed [W-1:0] ref_b,
  output logic signed [W-1:0] ref_c
);
  localparam int GW = W + 2;

  logic adv;
  logic v1, v2, v3;

  // whole pipe advances unless a result is waiting unaccepted
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      v3        <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      v1        <= in_valid;
      v2        <= v1;
      v3        <= v2;
      out_valid <= v3;
    end
  end

  logic signed [GW-1:0] ph [NPH];
  logic signed [GW-1:0] pp [NPH];
  logic signed [GW-1:0] sh [NPH];
  logic signed [GW-1:0] mx, mn;
  logic signed [W-1:0]  o  [NPH];

  svpwm_clarke #(.W(W), .K(K)) u_clarke (
    .clk(clk), .rst(rst), .en(adv),
    .alpha(alpha), .beta(beta), .v(ph)
  );

  svpwm_minmax #(.GW(GW)) u_minmax (
    .clk(clk), .rst(rst), .en(adv),
    .v(ph), .p(pp), .mx(mx), .mn(mn)
  );

  svpwm_inject #(.GW(GW)) u_inject (
    .clk(clk), .rst(rst), .en(adv),
    .p(pp), .mx(mx), .mn(mn), .r(sh)
  );

  svpwm_scale #(.W(W), .GW(GW), .G(G)) u_scale (
    .clk(clk), .rst(rst), .en(adv && v3),
    .r(sh), .o(o)
  );

  assign ref_a = o[PH_A];
  assign ref_b = o[PH_B];
  assign ref_c = o[PH_C];

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && ref_a == 0 && ref_b == 0 && ref_c == 0); // R8
  AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> v1); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(ref_a) && $stable(ref_b)
                               && $stable(ref_c)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !v3 |=> $stable(ref_a) && $stable(ref_b) && $stable(ref_c)); // R7
endmodule

// File: tb/tb_svpwm_refgen.sv
module tb_svpwm_refgen;
  localparam int N = 289;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] alpha = '0;
  logic signed [15:0] beta = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] ref_a, ref_b, ref_c;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  int va_arr [N];
  int vb_arr [N];
  int ea [N];
  int eb [N];
  int ec [N];

  always #4 clk = ~clk;

  svpwm_refgen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .alpha(alpha), .beta(beta), .out_valid(out_valid), .out_ready(out_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      report();
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint scl(input longint x);
    longint q;
    q = (x * 18919 + 8192) >>> 14;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  function automatic void model(input int a, input int b, output int ra, output int rb, output int rc);
    longint kb, hf, pa, pb, pc, mx, mn, off;
    kb = (longint'(b) * 28378 + 16384) >>> 15;
    hf = longint'(a) >>> 1;
    pa = a;
    pb = kb - hf;
    pc = -kb - hf;
    mx = pa; mn = pa;
    if (pb > mx) mx = pb;
    if (pc > mx) mx = pc;
    if (pb < mn) mn = pb;
    if (pc < mn) mn = pc;
    off = -((mx + mn) >>> 1);
    ra = int'(scl(pa + off));
    rb = int'(scl(pb + off));
    rc = int'(scl(pc + off));
  endfunction

  task automatic check_refs(input int xa, input int xb, input int xc, input string tag);
    check(ref_a == xa, {tag, " refA"}, ref_a, xa);
    check(ref_b == xb, {tag, " refB"}, ref_b, xb);
    check(ref_c == xc, {tag, " refC"}, ref_c, xc);
  endtask

  // one command in, wait for its result; returns negedges until out_valid
  task automatic send_one(input int a, input int b, output int lat);
    @(negedge clk);
    alpha = 16'(a);
    beta = 16'(b);
    in_valid = 1'b1;
    out_ready = 1'b1;
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      if (out_valid) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic run_stream(input bit bp, input string tag);
    int idx = 0;
    int oidx = 0;
    int cyc = 0;
    bit in_fire = 0;
    bit stall_prev = 0;
    logic signed [15:0] sa = '0, sb = '0, sc = '0;
    while (oidx < N && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (in_fire) idx++;
      if (idx < N) begin
        in_valid = 1'b1;
        alpha = 16'(va_arr[idx]);
        beta = 16'(vb_arr[idx]);
      end else begin
        in_valid = 1'b0;
      end
      out_ready = bp ? ((cyc % 5) != 2 && (cyc % 7) != 3) : 1'b1;
      #1;
      if (stall_prev) begin
        // R6: waiting result must not move
        check(out_valid && ref_a == sa && ref_b == sb && ref_c == sc,
              {tag, " R6 stall hold"}, ref_a, sa);
      end
      if (out_valid && !out_ready)
        check(!in_ready, {tag, " R6 in_ready low in stall"}, in_ready, 0);
      in_fire = in_valid && in_ready;
      if (out_valid && out_ready) begin
        check_refs(ea[oidx], eb[oidx], ec[oidx], {tag, " R1 R2 R3 R4 sweep"});
        oidx++;
      end
      stall_prev = out_valid && !out_ready;
      sa = ref_a; sb = ref_b; sc = ref_c;
    end
    check(oidx == N, {tag, " R6 result count"}, oidx, N);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, {tag, " R5 no extra result"}, out_valid, 0);
  endtask

  initial begin
    int lat;
    int xa, xb, xc;
    int n;
    n = 0;
    for (int i = 0; i < 17; i++) begin
      for (int j = 0; j < 17; j++) begin
        va_arr[n] = (i == 16) ? 32767 : -32768 + i * 4096;
        vb_arr[n] = (j == 16) ? 32767 : -32768 + j * 4096;
        model(va_arr[n], vb_arr[n], ea[n], eb[n], ec[n]);
        n++;
      end
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8 out_valid after reset", out_valid, 0);
    check(in_ready, "R8 in_ready after reset", in_ready, 1);
    check_refs(0, 0, 0, "R8 reset refs");

    // R5: latency and single pulse; R7 hold afterwards
    model(8192, 0, xa, xb, xc);
    send_one(8192, 0, lat);
    check(lat == 4, "R5 latency", lat, 4);
    check_refs(xa, xb, xc, "R1 R3 single vector");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      check(!out_valid, "R5 single pulse", out_valid, 0);
      check_refs(xa, xb, xc, "R7 hold between updates");
    end

    // R2: zero command gives zero references
    send_one(0, 0, lat);
    check_refs(0, 0, 0, "R2 zero command");

    // R4: saturation corner
    model(32767, 32767, xa, xb, xc);
    send_one(32767, 32767, lat);
    check(ref_a == 32767, "R4 clamp high refA", ref_a, 32767);
    check(ref_c == -32768, "R4 clamp low refC", ref_c, -32768);
    check(ref_b == xb, "R4 corner refB", ref_b, xb);
    model(-32768, -32768, xa, xb, xc);
    send_one(-32768, -32768, lat);
    check_refs(xa, xb, xc, "R4 negative corner");

    // sweeps: free-flowing then with back-pressure
    run_stream(1'b0, "flow");
    run_stream(1'b1, "stall");

    // R8: reset after activity clears outputs
    send_one(20000, -9000, lat);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8 mid-run reset valid", out_valid, 0);
    check_refs(0, 0, 0, "R8 mid-run reset refs");

    report();
  end
endmodule